// File: doc/BRIEF.md
# Selectable-Rate Configuration Clock Generator

The block divides a fast reference clock down to a configuration clock whose rate is chosen by a 3-bit rate code. There are five settings, nominally 3, 6, 12.5, 25 and 50 MHz from a 100 MHz reference, made by dividing by 32, 16, 8, 4 and 2. The 6 MHz setting (code 1) is the usual choice a configuration stream carries. After reset, the output always runs at the slowest setting.

A configuration sequencer changes the rate partway through a load. It presents new rate bits together with a one-cycle load strobe. The loaded value is only held as pending, and it becomes the active rate at the next falling edge of the output clock, so every high and low phase has a full width. A one-cycle tick marks each rising edge of the output for synchronous logic in the reference domain. Dropping the enable parks the output high with the divider cleared.

Top module: `cfg_clk_gen`

## Requirements
- R1: After reset `cfg_clk_o` is 1 and `tick_o` is 0. Until a load strobe is seen, the output period is 32 reference cycles, whatever value `rate_code_i` carries.
- R2: After a load, codes 0, 1, 2, 3 and 4 give output periods of 32, 16, 8, 4 and 2 reference cycles. High and low phases are each half the period.
- R3: Codes 5, 6 and 7 are loaded as code 0, which gives a period of 32 cycles.
- R4: `rate_code_i` is sampled only in a cycle where `rate_load_i` is 1. Changing it at any other time has no effect on the period.
- R5: A loaded rate takes effect at the next falling edge of `cfg_clk_o`. If the load lands in a high phase, that high phase keeps its old width and the following low phase uses the new width.
- R6: `tick_o` is high for exactly one reference cycle. It is high in the first cycle in which `cfg_clk_o` is 1 after being 0, and at no other time.
- R7: While `en_i` is 0, `cfg_clk_o` is 1 and `tick_o` is 0. After `en_i` returns to 1, the first high phase lasts a full half period of the active rate.
- R8: A rate loaded while `en_i` is 0 becomes active at the first falling edge after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enables the divider; when low the output is held high |
| rate_code_i | input | 3 | Rate selection bits from the sequencer |
| rate_load_i | input | 1 | One-cycle strobe that captures `rate_code_i` |
| cfg_clk_o | output | 1 | Divided configuration clock |
| tick_o | output | 1 | One-cycle pulse at each rising edge of `cfg_clk_o` |

## Verification
The assertions assume that `rate_load_i` and `rate_code_i` are synchronous to the reference clock. They also assume that `en_i` changes only between edges. They do not constrain how often loads arrive. The bench drives every input on the falling reference edge and makes each strobe exactly one cycle wide. It loads only during the high phase of a slow setting when it checks the switch point, so the expected mixed period is unambiguous. Each period measurement waits two full ticks after a load, so that it sees only the new setting.

// File: rtl/cfg_clk_pkg.sv
package cfg_clk_pkg;
  localparam int unsigned CODE_W_DEF    = 3;
  localparam int unsigned NUM_RATES_DEF = 5;
  localparam int unsigned SLOW_DIV_DEF  = 32;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  function automatic int unsigned half_of(input int unsigned slow_half, input int unsigned idx);
    return slow_half >> idx;
  endfunction
endpackage

// File: rtl/cfg_clk_rate_ctrl.sv
module cfg_clk_rate_ctrl
  import cfg_clk_pkg::*;
#(
  parameter int unsigned CODE_W    = CODE_W_DEF,
  parameter int unsigned NUM_RATES = NUM_RATES_DEF,
  parameter int unsigned SLOW_HALF = SLOW_DIV_DEF / 2,
  parameter int unsigned HALF_W    = $clog2(SLOW_HALF) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  input  logic              fall_i,
  output logic [HALF_W-1:0] half_o
);
  logic [HALF_W-1:0] half_lut [NUM_RATES];
  logic [HALF_W-1:0] code_half;
  logic [HALF_W-1:0] pend_q, act_q;
  logic              pend_vld_q, seen_load_q;

  for (genvar k = 0; k < NUM_RATES; k++) begin : g_lut
    assign half_lut[k] = HALF_W'(half_of(SLOW_HALF, k));
  end

  // out-of-range codes fall back to the slowest entry
  always_comb begin
    code_half = half_lut[0];
    for (int k = 0; k < NUM_RATES; k++) begin
      if (code_i == CODE_W'(k)) code_half = half_lut[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= HALF_W'(SLOW_HALF);
      act_q       <= HALF_W'(SLOW_HALF);
      pend_vld_q  <= 1'b0;
      seen_load_q <= 1'b0;
    end else begin
      if (fall_i && pend_vld_q) begin
        act_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end
      if (load_i) begin
        pend_q      <= code_half;
        pend_vld_q  <= 1'b1;
        seen_load_q <= 1'b1;
      end
    end
  end

  assign half_o = act_q;

  // R5
  act_change_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(fall_i));
  // R1
  slow_until_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != HALF_W'(SLOW_HALF)) |-> seen_load_q);
  // R2
  legal_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act_q) == 1);
endmodule

// File: rtl/cfg_clk_divider.sv
module cfg_clk_divider
  import cfg_clk_pkg::*;
#(
  parameter int unsigned HALF_W = 5,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              clk_o,
  output logic              tick_o,
  output logic              fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             clk_q, tick_q;
  logic             last;
  phase_e           phase;

  assign last   = ({{(HALF_W-CNT_W){1'b0}}, cnt_q} == half_i - HALF_W'(1));
  assign phase  = !en_i ? PH_IDLE : (clk_q ? PH_HIGH : PH_LOW);
  assign fall_o = (phase == PH_HIGH) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      clk_q  <= 1'b1;
      tick_q <= 1'b0;
    end else if (phase == PH_IDLE) begin
      cnt_q  <= '0;
      clk_q  <= 1'b1;
      tick_q <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      clk_q  <= ~clk_q;
      tick_q <= (phase == PH_LOW);
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign clk_o  = clk_q;
  assign tick_o = tick_q;

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{(HALF_W-CNT_W){1'b0}}, cnt_q} < half_i);
endmodule

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen
  import cfg_clk_pkg::*;
#(
  parameter int unsigned CODE_W    = CODE_W_DEF,
  parameter int unsigned NUM_RATES = NUM_RATES_DEF,
  parameter int unsigned SLOW_DIV  = SLOW_DIV_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              rate_load_i,
  output logic              cfg_clk_o,
  output logic              tick_o
);
  localparam int unsigned SLOW_HALF = SLOW_DIV / 2;
  localparam int unsigned CNT_W     = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
  localparam int unsigned HALF_W    = CNT_W + 1;

  logic [HALF_W-1:0] half;
  logic              fall;

  cfg_clk_rate_ctrl #(
    .CODE_W   (CODE_W),
    .NUM_RATES(NUM_RATES),
    .SLOW_HALF(SLOW_HALF),
    .HALF_W   (HALF_W)
  ) u_rate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(rate_code_i),
    .load_i(rate_load_i),
    .fall_i(fall),
    .half_o(half)
  );

  cfg_clk_divider #(
    .HALF_W(HALF_W),
    .CNT_W (CNT_W)
  ) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .half_i(half),
    .clk_o (cfg_clk_o),
    .tick_o(tick_o),
    .fall_o(fall)
  );

  // R6
  tick_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (cfg_clk_o && !$past(cfg_clk_o)));
  // R6
  rise_has_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_clk_o) && $past(en_i) |-> tick_o);
  // R7
  park_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cfg_clk_o && !tick_o));
endmodule

// File: tb/tb_cfg_clk_gen.sv
module tb_cfg_clk_gen;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic [2:0] rate_code_i = 3'd0;
  logic       rate_load_i = 1'b0;
  logic       cfg_clk_o, tick_o;

  int checks = 0;
  int errors = 0;

  cfg_clk_gen dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .rate_code_i(rate_code_i),
    .rate_load_i(rate_load_i),
    .cfg_clk_o  (cfg_clk_o),
    .tick_o     (tick_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk_i); while (!tick_o);
  endtask

  // reference cycles from the current tick to the next one
  task automatic period(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tick_o);
  endtask

  task automatic load(input logic [2:0] code);
    @(negedge clk_i);
    rate_code_i = code;
    rate_load_i = 1'b1;
    @(negedge clk_i);
    rate_load_i = 1'b0;
  endtask

  task automatic settled_period(output int n);
    wait_tick();
    wait_tick();
    period(n);
  endtask

  task automatic t_reset();
    int n;
    chk("R1 clk after reset", int'(cfg_clk_o), 1);
    chk("R1 tick after reset", int'(tick_o), 0);
    rate_code_i = 3'd4;
    wait_tick();
    period(n);
    chk("R1 slow before load", n, 32);
    period(n);
    chk("R1 slow before load 2nd", n, 32);
  endtask

  task automatic t_rates();
    int n;
    int exp_tab[8] = '{32, 16, 8, 4, 2, 32, 32, 32};
    for (int c = 0; c < 8; c++) begin
      load(3'(c));
      settled_period(n);
      if (c < 5) chk($sformatf("R2 code %0d", c), n, exp_tab[c]);
      else       chk($sformatf("R3 code %0d", c), n, exp_tab[c]);
    end
  endtask

  task automatic t_ignore();
    int n;
    load(3'd2);
    settled_period(n);
    @(negedge clk_i);
    rate_code_i = 3'd4;
    repeat (20) @(negedge clk_i);
    rate_code_i = 3'd0;
    settled_period(n);
    chk("R4 code ignored without load", n, 8);
  endtask

  task automatic t_switch_point();
    int n;
    load(3'd0);
    wait_tick();
    wait_tick();
    rate_code_i = 3'd3;
    rate_load_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      rate_load_i = 1'b0;
    end while (!tick_o);
    chk("R5 mixed period old high new low", n, 18);
    period(n);
    chk("R5 new period after switch", n, 4);
  endtask

  task automatic t_tick_shape();
    int ticks = 0, rises = 0, bad = 0;
    logic prev;
    load(3'd3);
    wait_tick();
    prev = cfg_clk_o;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (cfg_clk_o && !prev) rises++;
      if (tick_o) begin
        ticks++;
        if (!(cfg_clk_o && !prev)) bad++;
      end
      prev = cfg_clk_o;
    end
    chk("R6 ticks match rising edges", ticks, rises);
    chk("R6 ticks off a rising edge", bad, 0);
    chk("R6 tick count", ticks, 50);
  endtask

  task automatic t_enable();
    int lows = 0, ticks = 0, n;
    load(3'd0);
    wait_tick();
    wait_tick();
    @(negedge clk_i);
    en_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (!cfg_clk_o) lows++;
      if (tick_o) ticks++;
    end
    chk("R7 held high while disabled", lows, 0);
    chk("R7 no tick while disabled", ticks, 0);
    en_i = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (cfg_clk_o);
    chk("R7 first high after enable", n, 16);
  endtask

  task automatic t_load_disabled();
    int n;
    wait_tick();
    @(negedge clk_i);
    en_i = 1'b0;
    load(3'd2);
    repeat (5) @(negedge clk_i);
    en_i = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (cfg_clk_o);
    chk("R8 high after enable keeps old rate", n, 16);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tick_o);
    chk("R8 new low width after enable", n, 4);
    period(n);
    chk("R8 new period", n, 8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rates();
    t_ignore();
    t_switch_point();
    t_tick_shape();
    t_enable();
    t_load_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule